// File: doc/BRIEF.md
# Display Mode-Set Write Sequencer

This block changes the display mode of a legacy-compatible display controller without software walking the registers one by one. A single start pulse makes it read a stored parameter table and issue an ordered stream of byte writes on an I/O bus. The stream reaches the sequencer, misc output, CRT timing, graphics and attribute registers. The ordering rules that make a mode change safe are built into the order of the writes. The sequencer is held in reset while the timing registers are loaded. CRT write protection is removed before the timing registers are touched and restored at the end. Every attribute index carries the scan-enable bit, so the screen is never blanked.

The table is read through a combinational port: the block drives an address, and the byte must be valid in the same cycle. Each busy cycle carries exactly one bus access, either a write or the single status read that resets the attribute index/data toggle. When the last write has gone out, done pulses for one cycle.

Top module: `modeset_ctrl`

## Requirements
- R1: While reset is held, and after its release until start, busy, done, io_we and io_re are all 0.
- R2: In the first two busy cycles after start is accepted in idle, 0x00 is written to 0x3C4, then 0x01 is written to 0x3C5, which places the sequencer in reset.
- R3: Table bytes 1..4 then go to sequencer registers 1..4. Each register takes an index write to 0x3C4 followed by a data write to 0x3C5. Table byte 5 is then written once to 0x3C2.
- R4: Before any other CRT timing write, index 0x11 goes to 0x3D4 and table byte 23 goes to 0x3D5 with bit 7 cleared. Registers 0..24 then take table bytes 6..30 as index/data pairs on 0x3D4/0x3D5, with register 0x11 again written with bit 7 cleared. Finally register 0x11 is written with its full table value.
- R5: Graphics registers 0..8 take table bytes 31..39 as pairs on 0x3CE/0x3CF. Then 0x00 goes to 0x3C4 and 0x03 to 0x3C5, which releases the sequencer.
- R6: One read of 0x3DA happens after R5 and before any write to 0x3C0. Writes to 0x3C0 alternate index then data, and every index has bit 5 set.
- R7: When bit 0 of table byte 0 is 1, palette registers 0..15 take table bytes 40..55 after the status read. When that bit is 0, no palette write occurs.
- R8: Attribute registers 0x10..0x14 (index bytes 0x30..0x34) take table bytes 56..60. The stream then ends with 0x00 written to 0x3CC and 0x01 written to 0x3CA.
- R9: busy is 1 on every access cycle, with no gap. done is 1 for exactly the one cycle after the final write, and busy is 0 in that cycle.
- R10: A start pulse while busy has no effect on the access stream.
- R11: io_we and io_re are never 1 together, and neither is 1 outside busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a mode change (accepted only in idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final write |
| tbl_addr | output | TAW | Parameter table byte address |
| tbl_data | input | 8 | Table byte at tbl_addr, valid in the same cycle |
| io_we | output | 1 | I/O write strobe, one byte per cycle |
| io_re | output | 1 | I/O read strobe (status read) |
| io_addr | output | 16 | I/O port address |
| io_wdata | output | 8 | I/O write data |

## Verification
Some properties are checked on every cycle: that reads and writes never collide or leak outside busy, the done pulse and its placement against busy, scan-enable on every attribute index, and that register 0x11 is never written with its protect bit set inside the main timing loop. The exact order of the stream can only be shown by the bench's scenarios, which compare every access against a trace built from the table. Those scenarios also cover the presence or absence of the palette block, the final relock value, and a start pulse injected mid-sequence.

// File: rtl/modeset_pkg.sv
package modeset_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_SRST, PH_SEQ, PH_MISC, PH_UNLK, PH_CRTC, PH_LOCK,
    PH_GFX, PH_SRUN, PH_ARD, PH_PAL, PH_ATR, PH_GPOS, PH_DONE
  } phase_e;

  localparam logic [15:0] P_SEQ_IX = 16'h03C4;
  localparam logic [15:0] P_SEQ_DT = 16'h03C5;
  localparam logic [15:0] P_MISC   = 16'h03C2;
  localparam logic [15:0] P_CRT_IX = 16'h03D4;
  localparam logic [15:0] P_CRT_DT = 16'h03D5;
  localparam logic [15:0] P_GFX_IX = 16'h03CE;
  localparam logic [15:0] P_GFX_DT = 16'h03CF;
  localparam logic [15:0] P_ATR    = 16'h03C0;
  localparam logic [15:0] P_STAT   = 16'h03DA;
  localparam logic [15:0] P_GPOS_A = 16'h03CC;
  localparam logic [15:0] P_GPOS_B = 16'h03CA;

  localparam logic [7:0] PROT_REG  = 8'h11;
  localparam int         PROT_BIT  = 7;
  localparam logic [7:0] SCAN_ON   = 8'h20;
  localparam logic [7:0] SEQ_HOLD  = 8'h01;
  localparam logic [7:0] SEQ_RUN   = 8'h03;
endpackage

// File: rtl/modeset_fsm.sv
module modeset_fsm
  import modeset_pkg::*;
#(
  parameter int N_SEQ  = 4,
  parameter int N_CRTC = 25,
  parameter int N_GFX  = 9,
  parameter int N_PAL  = 16,
  parameter int N_ATR  = 5,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pal_flag,
  output phase_e        phase,
  output logic [CW-1:0] idx,
  output logic          half,
  output logic          busy,
  output logic          done
);
  phase_e        phase_q, phase_d, follow;
  logic [CW-1:0] idx_q, idx_d, cnt_last;
  logic          half_q, half_d, pal_q, pal_d, adv;

  always_comb begin
    case (phase_q)
      PH_SEQ:  cnt_last = CW'(N_SEQ - 1);
      PH_CRTC: cnt_last = CW'(N_CRTC - 1);
      PH_GFX:  cnt_last = CW'(N_GFX - 1);
      PH_PAL:  cnt_last = CW'(N_PAL - 1);
      PH_ATR:  cnt_last = CW'(N_ATR - 1);
      default: cnt_last = '0;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_SRST: follow = PH_SEQ;
      PH_SEQ:  follow = PH_MISC;
      PH_UNLK: follow = PH_CRTC;
      PH_CRTC: follow = PH_LOCK;
      PH_LOCK: follow = PH_GFX;
      PH_GFX:  follow = PH_SRUN;
      PH_SRUN: follow = PH_ARD;
      PH_PAL:  follow = PH_ATR;
      PH_ATR:  follow = PH_GPOS;
      PH_GPOS: follow = PH_DONE;
      default: follow = PH_IDLE;
    endcase
  end

  assign adv = (phase_q != PH_IDLE) || start;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    half_d  = half_q;
    pal_d   = pal_q;
    case (phase_q)
      PH_IDLE: begin
        phase_d = PH_SRST;
        idx_d   = '0;
        half_d  = 1'b0;
        pal_d   = pal_flag;
      end
      PH_MISC: phase_d = PH_UNLK;
      PH_ARD:  phase_d = pal_q ? PH_PAL : PH_ATR;
      PH_DONE: phase_d = PH_IDLE;
      default: begin
        if (!half_q) begin
          half_d = 1'b1;
        end else begin
          half_d = 1'b0;
          if (idx_q == cnt_last) begin
            idx_d   = '0;
            phase_d = follow;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
      pal_q   <= 1'b0;
    end else if (adv) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      half_q  <= half_d;
      pal_q   <= pal_d;
    end
  end

  assign phase = phase_q;
  assign idx   = idx_q;
  assign half  = half_q;
  assign busy  = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign done  = (phase_q == PH_DONE);

  // R10: once running, a sequence never drops back to idle before done
  assert_run_to_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_q != PH_GPOS) |=> busy);
endmodule

// File: rtl/modeset_opgen.sv
module modeset_opgen
  import modeset_pkg::*;
#(
  parameter int N_SEQ  = 4,
  parameter int N_CRTC = 25,
  parameter int N_GFX  = 9,
  parameter int N_PAL  = 16,
  parameter int N_ATR  = 5,
  parameter int TAW    = 6,
  parameter int CW     = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  phase_e         phase,
  input  logic [CW-1:0]  idx,
  input  logic           half,
  input  logic [7:0]     tbl_data,
  output logic [TAW-1:0] tbl_addr,
  output logic           io_we,
  output logic           io_re,
  output logic [15:0]    io_addr,
  output logic [7:0]     io_wdata
);
  localparam int OFS_SEQ  = 1;
  localparam int OFS_MISC = OFS_SEQ + N_SEQ;
  localparam int OFS_CRTC = OFS_MISC + 1;
  localparam int OFS_GFX  = OFS_CRTC + N_CRTC;
  localparam int OFS_PAL  = OFS_GFX + N_GFX;
  localparam int OFS_ATR  = OFS_PAL + N_PAL;

  logic [7:0] ix8, unprot;
  assign ix8    = 8'(idx);
  assign unprot = tbl_data & ~(8'h01 << PROT_BIT);

  always_comb begin
    case (phase)
      PH_SEQ:           tbl_addr = TAW'(OFS_SEQ + int'(idx));
      PH_MISC:          tbl_addr = TAW'(OFS_MISC);
      PH_UNLK, PH_LOCK: tbl_addr = TAW'(OFS_CRTC + int'(PROT_REG));
      PH_CRTC:          tbl_addr = TAW'(OFS_CRTC + int'(idx));
      PH_GFX:           tbl_addr = TAW'(OFS_GFX + int'(idx));
      PH_PAL:           tbl_addr = TAW'(OFS_PAL + int'(idx));
      PH_ATR:           tbl_addr = TAW'(OFS_ATR + int'(idx));
      default:          tbl_addr = '0;
    endcase
  end

  always_comb begin
    io_we    = 1'b1;
    io_re    = 1'b0;
    io_addr  = '0;
    io_wdata = '0;
    case (phase)
      PH_SRST, PH_SRUN: begin
        io_addr  = half ? P_SEQ_DT : P_SEQ_IX;
        io_wdata = half ? ((phase == PH_SRST) ? SEQ_HOLD : SEQ_RUN) : 8'h00;
      end
      PH_SEQ: begin
        io_addr  = half ? P_SEQ_DT : P_SEQ_IX;
        io_wdata = half ? tbl_data : ix8 + 8'd1;
      end
      PH_MISC: begin
        io_addr  = P_MISC;
        io_wdata = tbl_data;
      end
      PH_UNLK, PH_LOCK: begin
        io_addr  = half ? P_CRT_DT : P_CRT_IX;
        io_wdata = !half ? PROT_REG : ((phase == PH_UNLK) ? unprot : tbl_data);
      end
      PH_CRTC: begin
        io_addr  = half ? P_CRT_DT : P_CRT_IX;
        io_wdata = !half ? ix8 : ((ix8 == PROT_REG) ? unprot : tbl_data);
      end
      PH_GFX: begin
        io_addr  = half ? P_GFX_DT : P_GFX_IX;
        io_wdata = half ? tbl_data : ix8;
      end
      PH_ARD: begin
        io_we   = 1'b0;
        io_re   = 1'b1;
        io_addr = P_STAT;
      end
      PH_PAL, PH_ATR: begin
        io_addr  = P_ATR;
        io_wdata = half ? tbl_data
                 : (SCAN_ON | ((phase == PH_ATR) ? ix8 + 8'(N_PAL) : ix8));
      end
      PH_GPOS: begin
        io_addr  = half ? P_GPOS_B : P_GPOS_A;
        io_wdata = half ? 8'h01 : 8'h00;
      end
      default: io_we = 1'b0;
    endcase
  end

  // R6: every attribute index write keeps display scan enabled
  assert_attr_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == P_ATR && !half) |-> io_wdata[5]);
  // R4: protect bit stays clear while the main CRT loop writes register 0x11
  assert_crtc_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == P_CRT_DT && phase == PH_CRTC && ix8 == PROT_REG)
      |-> !io_wdata[PROT_BIT]);
endmodule

// File: rtl/modeset_ctrl.sv
module modeset_ctrl
  import modeset_pkg::*;
#(
  parameter int N_SEQ  = 4,
  parameter int N_CRTC = 25,
  parameter int N_GFX  = 9,
  parameter int N_PAL  = 16,
  parameter int N_ATR  = 5,
  parameter int TAW    = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic [TAW-1:0] tbl_addr,
  input  logic [7:0]     tbl_data,
  output logic           io_we,
  output logic           io_re,
  output logic [15:0]    io_addr,
  output logic [7:0]     io_wdata
);
  localparam int CW = $clog2(N_CRTC + N_PAL + 1);

  logic          rst_meta, rst_s;
  phase_e        phase;
  logic [CW-1:0] idx;
  logic          half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  modeset_fsm #(
    .N_SEQ(N_SEQ), .N_CRTC(N_CRTC), .N_GFX(N_GFX),
    .N_PAL(N_PAL), .N_ATR(N_ATR), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s), .start(start), .pal_flag(tbl_data[0]),
    .phase(phase), .idx(idx), .half(half), .busy(busy), .done(done)
  );

  modeset_opgen #(
    .N_SEQ(N_SEQ), .N_CRTC(N_CRTC), .N_GFX(N_GFX),
    .N_PAL(N_PAL), .N_ATR(N_ATR), .TAW(TAW), .CW(CW)
  ) u_opgen (
    .clk(clk), .rst_n(rst_s), .phase(phase), .idx(idx), .half(half),
    .tbl_data(tbl_data), .tbl_addr(tbl_addr), .io_we(io_we), .io_re(io_re),
    .io_addr(io_addr), .io_wdata(io_wdata)
  );

  assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_s)
    !(io_we && io_re));
  assert_access_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (io_we || io_re) |-> busy);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);
  assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy) |-> done);
endmodule

// File: tb/tb_modeset_ctrl.sv
module tb_modeset_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, io_we, io_re;
  logic [5:0]  tbl_addr;
  logic [7:0]  tbl_data, io_wdata;
  logic [15:0] io_addr;
  logic [7:0]  tbl [64];

  int total = 0;
  int fails = 0;
  int n_exp;
  bit          e_rd   [200];
  logic [15:0] e_addr [200];
  logic [7:0]  e_data [200];
  string       e_req  [200];

  always #2.5 clk = ~clk;
  assign tbl_data = tbl[tbl_addr];

  modeset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .io_we(io_we), .io_re(io_re),
    .io_addr(io_addr), .io_wdata(io_wdata)
  );

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run hung, got no finish expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic add(input bit rd, input logic [15:0] a, input logic [7:0] d, input string r);
    e_rd[n_exp] = rd; e_addr[n_exp] = a; e_data[n_exp] = d; e_req[n_exp] = r;
    n_exp++;
  endtask

  // expected trace built from the requirement text and the table contents
  task automatic build_exp();
    n_exp = 0;
    add(0, 16'h03C4, 8'h00, "R2"); add(0, 16'h03C5, 8'h01, "R2");
    for (int i = 0; i < 4; i++) begin
      add(0, 16'h03C4, 8'(i + 1), "R3"); add(0, 16'h03C5, tbl[1 + i], "R3");
    end
    add(0, 16'h03C2, tbl[5], "R3");
    add(0, 16'h03D4, 8'h11, "R4"); add(0, 16'h03D5, tbl[23] & 8'h7F, "R4");
    for (int i = 0; i < 25; i++) begin
      add(0, 16'h03D4, 8'(i), "R4");
      add(0, 16'h03D5, (i == 17) ? (tbl[6 + i] & 8'h7F) : tbl[6 + i], "R4");
    end
    add(0, 16'h03D4, 8'h11, "R4"); add(0, 16'h03D5, tbl[23], "R4");
    for (int i = 0; i < 9; i++) begin
      add(0, 16'h03CE, 8'(i), "R5"); add(0, 16'h03CF, tbl[31 + i], "R5");
    end
    add(0, 16'h03C4, 8'h00, "R5"); add(0, 16'h03C5, 8'h03, "R5");
    add(1, 16'h03DA, 8'h00, "R6");
    if (tbl[0][0]) begin
      for (int i = 0; i < 16; i++) begin
        add(0, 16'h03C0, 8'h20 | 8'(i), "R7"); add(0, 16'h03C0, tbl[40 + i], "R7");
      end
    end
    for (int i = 0; i < 5; i++) begin
      add(0, 16'h03C0, 8'h30 + 8'(i), "R8"); add(0, 16'h03C0, tbl[56 + i], "R8");
    end
    add(0, 16'h03CC, 8'h00, "R8"); add(0, 16'h03CA, 8'h01, "R8");
  endtask

  task automatic run_mode(input int poke_at);
    build_exp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < n_exp; k++) begin
      bit ok;
      if (k == poke_at) start = 1'b1;       // R10: start while busy
      if (k == poke_at + 1) start = 1'b0;
      if (e_rd[k]) ok = busy && io_re && !io_we && io_addr == e_addr[k];
      else ok = busy && io_we && !io_re && io_addr == e_addr[k] && io_wdata == e_data[k];
      check(ok, (poke_at >= 0 && k > poke_at) ? {e_req[k], "/R10"} : e_req[k],
        $sformatf("step %0d: got busy=%0b we=%0b re=%0b addr=%h data=%h expected %s addr=%h data=%h",
          k, busy, io_we, io_re, io_addr, io_wdata, e_rd[k] ? "read" : "write",
          e_addr[k], e_data[k]));
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy && !io_we && !io_re, "R9",
      $sformatf("after last write: got done=%0b busy=%0b we=%0b re=%0b expected 1 0 0 0",
        done, busy, io_we, io_re));
    @(negedge clk);
    check(!done && !busy && !io_we && !io_re, "R9",
      $sformatf("cycle after done: got done=%0b busy=%0b expected 0 0", done, busy));
  endtask

  initial begin
    logic [7:0] crt [25] = '{8'h5F, 8'h4F, 8'h50, 8'h82, 8'h54, 8'h80, 8'hBF, 8'h1F,
                             8'h00, 8'h41, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                             8'h9C, 8'h8E, 8'h8F, 8'h28, 8'h40, 8'h96, 8'hB9, 8'hA3, 8'hFF};
    logic [7:0] gfx [9] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h05, 8'h0F, 8'hFF};
    logic [7:0] atr [5] = '{8'h41, 8'h00, 8'h0F, 8'h00, 8'h00};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) tbl[i] = 8'h00;

    // R1: reset state, held and just after release
    repeat (3) @(negedge clk);
    check(!busy && !done && !io_we && !io_re, "R1",
      $sformatf("in reset: got busy=%0b done=%0b we=%0b re=%0b expected 0", busy, done, io_we, io_re));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !io_we && !io_re, "R1",
      $sformatf("idle after reset: got busy=%0b done=%0b we=%0b re=%0b expected 0", busy, done, io_we, io_re));

    // directed 320x200 256-colour setting with palette, start poked mid-run
    tbl[0] = 8'h01;
    tbl[1] = 8'h01; tbl[2] = 8'h0F; tbl[3] = 8'h00; tbl[4] = 8'h0E;
    tbl[5] = 8'h63;
    for (int i = 0; i < 25; i++) tbl[6 + i] = crt[i];
    for (int i = 0; i < 9; i++) tbl[31 + i] = gfx[i];
    for (int i = 0; i < 16; i++) tbl[40 + i] = 8'(i);
    for (int i = 0; i < 5; i++) tbl[56 + i] = atr[i];
    run_mode(20);

    // R7: same table with palette flag cleared, start poked near the end
    tbl[0] = 8'h00;
    run_mode(90);

    // R4 corner: protect bit clear in table; R6 corner: all-ones attribute data
    tbl[23] = 8'h0E;
    for (int i = 56; i < 61; i++) tbl[i] = 8'hFF;
    tbl[0] = 8'hFE;                         // bit 0 clear, other flag bits ignored
    run_mode(-1);

    // random tables, random palette flag
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 61; i++) tbl[i] = 8'($urandom);
      run_mode((r % 2 == 0) ? int'($urandom % 90) : -1);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule